// File: doc/BRIEF.md
# Power-Down and Output-Enable Controller

This block turns a handful of control register bits, an external power-down pin and a sync activity input into a power-down request and four output-enable signals. The four enables cover the primary data group (red and green channels), the secondary data group (blue channel), the clock and sync outputs, and the sync-on-green output. A pad ring uses the enables to drive or float its pins. The power-down request goes to the analog power gating.

Several sources can float the outputs: a software power-down bit, a global three-state bit, per-group enable bits, the power-down pin and auto power-down on loss of sync. A polarity bit selects the active level of the pin. A two-bit function field decides two things independently: whether an asserted pin powers the chip down, and whether the sync-on-green output also floats. The sync-on-green output stays on during software power-down, global three-state and auto power-down. Only its own three-state bit or a pin function can float it.

Loss of sync is declared when no edge of the sync input arrives within a programmable number of clock cycles. The first edge after that clears it. All five outputs are registered.

Top module: `pwr_oe_ctrl`

## Requirements
- R1: Register map and reset values, all readable at the same addresses. Unused bits and address 3 read 0.
  - Address 0: bit 0 primary enable (reset 1), bit 1 secondary enable (reset 0), bit 2 global three-state (reset 0), bit 3 sync-on-green three-state (reset 0).
  - Address 1: bit 0 software power-down (reset 0), bit 1 pin polarity (reset 1), bits 3:2 pin function (reset 00), bit 4 auto power-down enable (reset 1).
  - Address 2: sync timeout in cycles (reset 32).
- R2: Pin polarity. With polarity 1 the pin is asserted when high. With polarity 0 it is asserted when low.
- R3: While the pin is not asserted, the pin function field has no effect on any output.
- R4: While the pin is asserted, the pin function field acts as follows:
  - 00: pd_o=1, and every output except sync-on-green floats.
  - 01: pd_o=1, and all outputs float.
  - 10: pd_o=0, and every output except sync-on-green floats.
  - 11: pd_o=0, and all outputs float.
- R5: Software power-down sets pd_o and floats the primary, secondary and clock/sync groups. Sync-on-green stays enabled.
- R6: Global three-state floats every group except sync-on-green. The sync-on-green three-state bit floats only that output.
- R7: The primary enable gates only the primary group, and the secondary enable gates only the secondary group. A value of 0 means high impedance.
- R8: With auto power-down enabled, a stretch of cycles with no sync edge that reaches the timeout sets pd_o and floats every group except sync-on-green. With auto power-down disabled, loss of sync has no effect.
- R9: The first sync edge after a loss of sync clears the auto power-down.
- R10: Every output changes on the clock edge after the one that updates its cause. A register write therefore reaches the outputs two clock edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 8 | Read data, combinational |
| pd_pin_i | input | 1 | External power-down pin |
| sync_i | input | 1 | Sync activity input, already in the clock domain |
| pd_o | output | 1 | Power-down request |
| prim_oe_o | output | 1 | Primary data group enable |
| sec_oe_o | output | 1 | Secondary data group enable |
| clksync_oe_o | output | 1 | Clock and sync output enable |
| sog_oe_o | output | 1 | Sync-on-green output enable |

## Verification
The assertions take for granted that sync_i and pd_pin_i are already synchronous to clk_i. They also assume the timeout register is not zero whenever a sync edge is claimed to clear the loss state. The stimulus changes both inputs only on falling clock edges. It writes a nonzero timeout before exercising loss of sync, and it waits well past the timeout before it samples the outputs.

// File: rtl/pwr_oe_pkg.sv
package pwr_oe_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_OE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PWR = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_TMO = 2'd2;

  typedef enum logic [1:0] {
    PF_OFF_KEEP_SOG = 2'b00,
    PF_OFF_ALL      = 2'b01,
    PF_ON_KEEP_SOG  = 2'b10,
    PF_ON_ALL       = 2'b11
  } pin_func_e;

  typedef struct packed {
    logic      prim_en;
    logic      sec_en;
    logic      all_tri;
    logic      sog_tri;
    logic      sw_pd;
    logic      pin_pol;
    pin_func_e pin_func;
    logic      auto_en;
  } ctl_t;
endpackage

// File: rtl/pwr_oe_regs.sv
module pwr_oe_regs
  import pwr_oe_pkg::*;
#(
  parameter int unsigned TMO_W   = 8,
  parameter int unsigned TMO_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctl_t              ctl_o,
  output logic [TMO_W-1:0]  tmo_o
);
  ctl_t             ctl_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{prim_en: 1'b1, sec_en: 1'b0, all_tri: 1'b0, sog_tri: 1'b0,
                 sw_pd: 1'b0, pin_pol: 1'b1, pin_func: PF_OFF_KEEP_SOG,
                 auto_en: 1'b1};
      tmo_q <= TMO_W'(TMO_RST);
    end else if (we_i) begin
      case (waddr_i)
        ADR_OE: begin
          ctl_q.prim_en <= wdata_i[0];
          ctl_q.sec_en  <= wdata_i[1];
          ctl_q.all_tri <= wdata_i[2];
          ctl_q.sog_tri <= wdata_i[3];
        end
        ADR_PWR: begin
          ctl_q.sw_pd    <= wdata_i[0];
          ctl_q.pin_pol  <= wdata_i[1];
          ctl_q.pin_func <= pin_func_e'(wdata_i[3:2]);
          ctl_q.auto_en  <= wdata_i[4];
        end
        ADR_TMO: tmo_q <= wdata_i[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      ADR_OE:  rdata_o[3:0] = {ctl_q.sog_tri, ctl_q.all_tri, ctl_q.sec_en, ctl_q.prim_en};
      ADR_PWR: rdata_o[4:0] = {ctl_q.auto_en, ctl_q.pin_func, ctl_q.pin_pol, ctl_q.sw_pd};
      ADR_TMO: rdata_o = DATA_W'(tmo_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctl_o = ctl_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/sync_watch.sv
module sync_watch #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             lost_o
);
  logic             sync_q;
  logic [TMO_W-1:0] cnt_q;
  logic             edge_seen;

  assign edge_seen = sync_i ^ sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_i;
      if (edge_seen)          cnt_q <= '0;
      else if (cnt_q < tmo_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lost_o = (cnt_q >= tmo_i);

  // R9: an edge restarts the window
  a_r9_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && $stable(tmo_i) && tmo_i != '0) |=> !lost_o);
endmodule

// File: rtl/oe_decode.sv
module oe_decode
  import pwr_oe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic pin_i,
  input  logic sync_lost_i,
  output logic pd_o,
  output logic prim_oe_o,
  output logic sec_oe_o,
  output logic clksync_oe_o,
  output logic sog_oe_o
);
  logic pin_act, auto_pd, pin_pd, pin_all, main_tri, sog_off, pd_d;

  assign pin_act  = ctl_i.pin_pol ? pin_i : ~pin_i;
  assign auto_pd  = ctl_i.auto_en & sync_lost_i;
  assign pin_pd   = pin_act & ~ctl_i.pin_func[1];
  assign pin_all  = pin_act & ctl_i.pin_func[0];
  assign pd_d     = ctl_i.sw_pd | pin_pd | auto_pd;
  assign main_tri = ctl_i.sw_pd | ctl_i.all_tri | pin_act | auto_pd;
  assign sog_off  = ctl_i.sog_tri | pin_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o         <= 1'b0;
      prim_oe_o    <= 1'b1;
      sec_oe_o     <= 1'b0;
      clksync_oe_o <= 1'b1;
      sog_oe_o     <= 1'b1;
    end else begin
      pd_o         <= pd_d;
      prim_oe_o    <= ~main_tri & ctl_i.prim_en;
      sec_oe_o     <= ~main_tri & ctl_i.sec_en;
      clksync_oe_o <= ~main_tri;
      sog_oe_o     <= ~sog_off;
    end
  end

  a_r5_swpd_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_i.sw_pd) |-> (pd_o && !clksync_oe_o && !prim_oe_o && !sec_oe_o));
  a_r7_sec_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_i.sec_en) |-> !sec_oe_o);
  a_r4_pin_stay_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pin_act && ctl_i.pin_func[1] && !ctl_i.sw_pd && !auto_pd) |-> !pd_o);
  a_r3_quiet_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pin_act && !ctl_i.sw_pd && !ctl_i.all_tri && !ctl_i.sog_tri && !auto_pd)
      |-> (sog_oe_o && clksync_oe_o && !pd_o));
  a_r6_sog_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pin_act && !ctl_i.sog_tri) |-> sog_oe_o);
endmodule

// File: rtl/pwr_oe_ctrl.sv
module pwr_oe_ctrl
  import pwr_oe_pkg::*;
#(
  parameter int unsigned TMO_W   = 8,
  parameter int unsigned TMO_RST = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_waddr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic [1:0] reg_raddr_i,
  output logic [7:0] reg_rdata_o,
  input  logic       pd_pin_i,
  input  logic       sync_i,
  output logic       pd_o,
  output logic       prim_oe_o,
  output logic       sec_oe_o,
  output logic       clksync_oe_o,
  output logic       sog_oe_o
);
  ctl_t             ctl;
  logic [TMO_W-1:0] tmo;
  logic             lost;

  pwr_oe_regs #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) regs_i (
    .clk_i, .rst_ni, .we_i(reg_we_i), .waddr_i(reg_waddr_i), .wdata_i(reg_wdata_i),
    .raddr_i(reg_raddr_i), .rdata_o(reg_rdata_o), .ctl_o(ctl), .tmo_o(tmo)
  );

  sync_watch #(.TMO_W(TMO_W)) watch_i (
    .clk_i, .rst_ni, .sync_i, .tmo_i(tmo), .lost_o(lost)
  );

  oe_decode dec_i (
    .clk_i, .rst_ni, .ctl_i(ctl), .pin_i(pd_pin_i), .sync_lost_i(lost),
    .pd_o, .prim_oe_o, .sec_oe_o, .clksync_oe_o, .sog_oe_o
  );

  // R8: auto power-down acts only when enabled
  a_r8_auto_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctl.auto_en && !ctl.sw_pd && !ctl.all_tri && ctl.pin_pol && !pd_pin_i)
      |-> clksync_oe_o);
endmodule

// File: tb/pwr_oe_ctrl_tb_top.sv
module pwr_oe_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0; logic [1:0] waddr = '0, raddr = '0; logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pin = 1'b0, sync_r = 1'b0, sync_run = 1'b1;
  logic pd, prim, sec, cs, sog;
  int n_chk = 0, n_fail = 0;
  logic [7:0] sh0 = 8'h01, sh1 = 8'h12;
  logic lost_m = 1'b0;

  typedef struct { logic [4:0] v; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pwr_oe_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata), .pd_pin_i(pin), .sync_i(sync_r),
    .pd_o(pd), .prim_oe_o(prim), .sec_oe_o(sec), .clksync_oe_o(cs), .sog_oe_o(sog)
  );

  initial forever begin
    @(negedge clk);
    if (sync_run) sync_r = ~sync_r;
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs {pd, prim, sec, clksync, sog} from the requirements
  function automatic logic [4:0] model();
    logic act, apd, pdv, mt, so;
    act = sh1[1] ? pin : ~pin;
    apd = sh1[4] & lost_m;
    pdv = sh1[0] | (act & ~sh1[3]) | apd;
    mt  = sh1[0] | sh0[2] | act | apd;
    so  = sh0[3] | (act & sh1[2]);
    return {pdv, ~mt & sh0[0], ~mt & sh0[1], ~mt, ~so};
  endfunction

  task automatic expect_now(string tag);
    exp_t e;
    e.v = model(); e.tag = tag;
    q.push_back(e);
  endtask

  initial forever begin
    @(negedge clk);
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, {3'b0, pd, prim, sec, cs, sog}, {3'b0, e.v});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    if (a == 2'd0) sh0 = d & 8'h0f;
    if (a == 2'd1) sh1 = d & 8'h1f;
    @(negedge clk);
  endtask

  task automatic set_pin(logic v);
    @(negedge clk); pin = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    raddr = 2'd0; #1 check("R1 reg0 reset", rdata, 8'h01);
    raddr = 2'd1; #1 check("R1 reg1 reset", rdata, 8'h12);
    raddr = 2'd2; #1 check("R1 reg2 reset", rdata, 8'd32);
    raddr = 2'd3; #1 check("R1 reg3 reads 0", rdata, 8'h00);
    expect_now("R1 outputs after reset");

    wr(2'd0, 8'h02); expect_now("R7 secondary only");
    wr(2'd0, 8'hf3); raddr = 2'd0; #1 check("R1 reg0 unused bits", rdata, 8'h03);
    expect_now("R7 both groups");
    wr(2'd0, 8'h07); expect_now("R6 global three-state");
    wr(2'd0, 8'h0b); expect_now("R6 sog three-state only");
    wr(2'd0, 8'h03);

    // R10 latency: write presented, then two edges to outputs
    @(negedge clk); we = 1'b1; waddr = 2'd1; wdata = 8'h13;
    @(negedge clk); we = 1'b0;
    check("R10 no change after first edge", {7'b0, cs}, 8'h01);
    @(negedge clk);
    check("R10 change after second edge", {7'b0, cs}, 8'h00);
    sh1 = 8'h13;
    expect_now("R5 software power-down");
    wr(2'd1, 8'h12);

    for (int f = 0; f < 4; f++) begin
      wr(2'd1, 8'h12 | 8'(f << 2));
      set_pin(1'b1); expect_now($sformatf("R4 func %0d pin asserted", f));
      set_pin(1'b0); expect_now($sformatf("R3 func %0d pin idle", f));
    end
    wr(2'd1, 8'h15);
    set_pin(1'b1); expect_now("R2 pol 0 high is idle");
    set_pin(1'b0); expect_now("R2 pol 0 low is asserted");
    set_pin(1'b1);
    wr(2'd1, 8'h12); set_pin(1'b0);

    wr(2'd2, 8'd10);
    sync_run = 1'b0;
    repeat (5) @(negedge clk);
    expect_now("R8 before timeout");
    repeat (12) @(negedge clk);
    lost_m = 1'b1; expect_now("R8 auto power-down");
    @(negedge clk);
    sync_run = 1'b1;
    repeat (4) @(negedge clk);
    lost_m = 1'b0; expect_now("R9 cleared by edge");
    wr(2'd1, 8'h02);
    sync_run = 1'b0;
    repeat (20) @(negedge clk);
    lost_m = 1'b1; expect_now("R8 auto disabled");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule